// File: doc/BRIEF.md
# BCD Calendar Counter with Century Flag

This block keeps the time of day and the calendar date in packed BCD. A parameterised divider counts core clock cycles and produces one advance per second. The advance ripples through seconds, minutes, hours, day of week, day of month, month and year. Month lengths follow the leap-year rule. A century flag can be set to invert each time the year wraps. A stop bit kept in the seconds byte freezes counting. The host writes any field through a byte-wide write port addressed by register index.

The host reads through a visible copy of the registers. While the host signals that a read of the clock fields is in progress, the visible copy is frozen, but the live counters keep advancing. An update that falls due during a read is held back. It is copied into the visible registers when the read ends, or after a quarter of a second has passed, whichever comes first.

A small state machine controls the visible copy. It has three states. In VIEW_TRACK the copy follows the live counters every cycle. VIEW_TRACK goes to VIEW_HOLD when a read starts. In VIEW_HOLD the copy is frozen and no update is pending. VIEW_HOLD goes to VIEW_WAIT when the live time changes, and goes back to VIEW_TRACK, with a copy, when the read ends. In VIEW_WAIT an update is pending and the hold counter runs. VIEW_WAIT goes back to VIEW_TRACK, with a copy, when the read ends. It goes back to VIEW_HOLD, with a copy, when the hold window expires.

Top module: `rtc_calendar_core`

## Requirements
- R1: Seconds are held as BCD in bits 6:0 of register 0. They advance by one every CLKS_PER_SEC core cycles, count 00 to 59, and wrap to 00 with a carry into minutes.
- R2: Minutes are held as BCD in bits 6:0 of register 1, and bit 7 of register 1 always reads 0. Minutes wrap from 59 to 00 with a carry into hours. Hours are held as BCD in bits 5:0 of register 2. They wrap from 23 to 00, and that wrap advances the date.
- R3: Bit 7 of register 0 is the stop bit and can be read back. While it is 1, no field changes. Writing it back to 0 lets counting resume.
- R4: The day of month is held in register 4 bits 5:0, the month in register 5 bits 4:0, and the year in register 6, all in BCD. The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months. In February it wraps after 29 when the year is a multiple of four (year 00 included) and after 28 otherwise. The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00.
- R5: Register 2 bit 7 is the century enable and bit 6 is the century flag. When the year wraps from 99 to 00, the flag inverts if the enable is 1 and stays unchanged if the enable is 0.
- R6: The day of week is held in register 3 bits 2:0 and counts 1 to 7. It advances only when the hours wrap at midnight, and it wraps from 7 to 1.
- R7: A write to registers 0 to 6 takes effect at the next clock edge. It restarts the sub-second count, so the next advance comes exactly CLKS_PER_SEC cycles after the write.
- R8: rd_data returns the visible copy of the register selected by rd_addr. With no read in progress, the copy follows the live counters one cycle behind.
- R9: While rd_active is high, the visible copy does not change except when a pending update is released. A pending update is released HOLD_CYCLES = CLKS_PER_SEC/4 cycles after the live change, or one cycle after rd_active falls, whichever comes first.
- R10: The live time keeps advancing while the visible copy is held. After the read ends, the copy shows the live time including every second that passed.
- R11: After reset, all fields read 00 except day of week, date and month, which read 01. Stop, century enable and century flag read 0. Register 7 always reads 00, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Register index for the write |
| wr_data | input | 8 | Write data byte |
| rd_active | input | 1 | High while a host read of the clock fields is in progress |
| rd_addr | input | 3 | Register index for the read |
| rd_data | output | 8 | Visible copy of the selected register |

## Verification
The rollover chain is driven from two starting points for every month of every year 00 to 99: the last day of the month at 23:59:59, and 28 February. These runs separate the 28-, 29-, 30- and 31-day cases, and they separate leap years from common years. A one-minute run of plain seconds checks the BCD digit carries and the wrap into minutes. Separate setups check the day-of-week wrap, and all four combinations of century enable and century flag at the year wrap. The hold logic is tested with three read patterns: a read that outlasts the quarter-second window, a read that ends early, and a read that spans several seconds. Together they show whether an update is released by the timer, by the end of the read, or lost.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam logic [2:0] REG_SEC   = 3'd0;
    localparam logic [2:0] REG_MIN   = 3'd1;
    localparam logic [2:0] REG_HOUR  = 3'd2;
    localparam logic [2:0] REG_DOW   = 3'd3;
    localparam logic [2:0] REG_DATE  = 3'd4;
    localparam logic [2:0] REG_MONTH = 3'd5;
    localparam logic [2:0] REG_YEAR  = 3'd6;
    localparam logic [2:0] REG_CTRL  = 3'd7;

    typedef struct packed {
        logic       stop;
        logic [6:0] sec;
        logic [6:0] min;
        logic       ceb;
        logic       cb;
        logic [5:0] hour;
        logic [2:0] dow;
        logic [5:0] date;
        logic [4:0] month;
        logic [7:0] year;
    } cal_t;

    localparam cal_t CAL_RESET = '{stop: 1'b0, sec: 7'h00, min: 7'h00, ceb: 1'b0,
                                   cb: 1'b0, hour: 6'h00, dow: 3'd1, date: 6'h01,
                                   month: 5'h01, year: 8'h00};

    typedef enum logic [1:0] {
        VIEW_TRACK,
        VIEW_HOLD,
        VIEW_WAIT
    } view_state_e;

    // Add one to a two-digit packed BCD value
    function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
        if (v[3:0] >= 4'd9) begin
            return {v[7:4] + 4'd1, 4'd0};
        end
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Multiple of four in BCD: even tens digit with ones 0/4/8, odd tens with 2/6
    function automatic logic leap_year(input logic [7:0] y);
        if (y[4]) begin
            return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        end
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    function automatic logic [5:0] month_last(input logic [4:0] m, input logic [7:0] y);
        case (m)
            5'h02:                     return leap_year(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                   return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_sec_divider.sv
module rtc_sec_divider #(
    parameter int CLKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    input  logic restart,
    output logic tick
);
    localparam int CNT_W = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_SEC - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == LAST) && !halt && !restart;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (halt || restart || (cnt_q == LAST)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_time_keeper.sv
module rtc_time_keeper
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output cal_t       now_q
);
    cal_t       nxt;
    logic [5:0] last_day;

    assign last_day = month_last(now_q.month, now_q.year);

    always_comb begin
        nxt = now_q;
        if (wr_en) begin
            unique case (wr_addr)
                REG_SEC:   begin nxt.stop = wr_data[7]; nxt.sec = wr_data[6:0]; end
                REG_MIN:   nxt.min = wr_data[6:0];
                REG_HOUR:  begin nxt.ceb = wr_data[7]; nxt.cb = wr_data[6]; nxt.hour = wr_data[5:0]; end
                REG_DOW:   nxt.dow = wr_data[2:0];
                REG_DATE:  nxt.date = wr_data[5:0];
                REG_MONTH: nxt.month = wr_data[4:0];
                REG_YEAR:  nxt.year = wr_data;
                REG_CTRL:  ;
            endcase
        end else if (tick && !now_q.stop) begin
            if (now_q.sec >= 7'h59) begin
                nxt.sec = 7'h00;
                if (now_q.min >= 7'h59) begin
                    nxt.min = 7'h00;
                    if (now_q.hour >= 6'h23) begin
                        nxt.hour = 6'h00;
                        nxt.dow  = (now_q.dow >= 3'd7) ? 3'd1 : now_q.dow + 3'd1;
                        if (now_q.date >= last_day) begin
                            nxt.date = 6'h01;
                            if (now_q.month >= 5'h12) begin
                                nxt.month = 5'h01;
                                if (now_q.year >= 8'h99) begin
                                    nxt.year = 8'h00;
                                    nxt.cb   = now_q.cb ^ now_q.ceb;
                                end else begin
                                    nxt.year = bcd_inc8(now_q.year);
                                end
                            end else begin
                                nxt.month = 5'(bcd_inc8({3'b000, now_q.month}));
                            end
                        end else begin
                            nxt.date = 6'(bcd_inc8({2'b00, now_q.date}));
                        end
                    end else begin
                        nxt.hour = 6'(bcd_inc8({2'b00, now_q.hour}));
                    end
                end else begin
                    nxt.min = 7'(bcd_inc8({1'b0, now_q.min}));
                end
            end else begin
                nxt.sec = 7'(bcd_inc8({1'b0, now_q.sec}));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q <= CAL_RESET;
        end else begin
            now_q <= nxt;
        end
    end

    assert_stop_freezes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (now_q.stop && !wr_en) |=> $stable(now_q));

    assert_sec_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && tick && !now_q.stop && now_q.sec == 7'h59) |=> (now_q.sec == 7'h00));

    assert_min_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && now_q.sec < 7'h59) |=> $stable(now_q.min));

    assert_century_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !now_q.ceb) |=> $stable(now_q.cb));

    assert_dow_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && now_q.dow >= 3'd1 && now_q.dow <= 3'd7) |=> (now_q.dow >= 3'd1 && now_q.dow <= 3'd7));

endmodule

// File: rtl/rtc_view_hold.sv
module rtc_view_hold
    import rtc_cal_pkg::*;
#(
    parameter int HOLD_CYCLES = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_active,
    input  logic upd,
    input  cal_t live,
    output cal_t view_q
);
    localparam int HC_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [HC_W-1:0] HOLD_LAST = HC_W'(HOLD_CYCLES - 1);

    view_state_e     state_q, state_d;
    logic            copy_en;
    logic [HC_W-1:0] hold_cnt_q;

    always_comb begin
        state_d = state_q;
        copy_en = 1'b0;
        unique case (state_q)
            VIEW_TRACK: begin
                copy_en = 1'b1;
                if (rd_active) state_d = VIEW_HOLD;
            end
            VIEW_HOLD: begin
                if (!rd_active) begin
                    copy_en = 1'b1;
                    state_d = VIEW_TRACK;
                end else if (upd) begin
                    state_d = VIEW_WAIT;
                end
            end
            VIEW_WAIT: begin
                if (!rd_active) begin
                    copy_en = 1'b1;
                    state_d = VIEW_TRACK;
                end else if (hold_cnt_q == HOLD_LAST) begin
                    copy_en = 1'b1;
                    state_d = VIEW_HOLD;
                end
            end
            default: state_d = VIEW_TRACK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= VIEW_TRACK;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            view_q     <= CAL_RESET;
            hold_cnt_q <= '0;
        end else begin
            if (copy_en) view_q <= live;
            hold_cnt_q <= (state_q == VIEW_WAIT) ? hold_cnt_q + 1'b1 : '0;
        end
    end

    assert_frozen_in_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == VIEW_HOLD && rd_active) |=> $stable(view_q));

    assert_wait_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == VIEW_WAIT) |-> (hold_cnt_q <= HOLD_LAST));

    assert_release_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != VIEW_TRACK && !rd_active) |=> (view_q == $past(live)));

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int CLKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_active,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data
);
    localparam int HOLD_CYCLES = (CLKS_PER_SEC / 4 < 1) ? 1 : CLKS_PER_SEC / 4;

    cal_t live;
    cal_t view;
    logic field_wr;
    logic tick;

    assign field_wr = wr_en && (wr_addr != REG_CTRL);

    rtc_sec_divider #(.CLKS_PER_SEC(CLKS_PER_SEC)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .halt    (live.stop),
        .restart (field_wr),
        .tick    (tick)
    );

    rtc_time_keeper u_keep (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (field_wr),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .now_q   (live)
    );

    rtc_view_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_view (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_active (rd_active),
        .upd       (tick | field_wr),
        .live      (live),
        .view_q    (view)
    );

    always_comb begin
        unique case (rd_addr)
            REG_SEC:   rd_data = {view.stop, view.sec};
            REG_MIN:   rd_data = {1'b0, view.min};
            REG_HOUR:  rd_data = {view.ceb, view.cb, view.hour};
            REG_DOW:   rd_data = {5'b0, view.dow};
            REG_DATE:  rd_data = {2'b0, view.date};
            REG_MONTH: rd_data = {3'b0, view.month};
            REG_YEAR:  rd_data = view.year;
            REG_CTRL:  rd_data = 8'h00;
        endcase
    end

    assert_ctrl_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == REG_CTRL) |-> (rd_data == 8'h00));

endmodule

// File: tb/rtc_calendar_core_bench.sv
module rtc_calendar_core_bench;
    localparam int CPS  = 16;
    localparam int HOLD = CPS / 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_active = 1'b0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;
    logic [7:0] snap [7];

    rtc_calendar_core #(.CLKS_PER_SEC(CPS)) u_rtc_calendar_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_active(rd_active), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // 10 ns period
    always #5 clk = ~clk;

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int dim(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic snap_all();
        for (int a = 0; a < 4; a++) rd(3'(a), snap[a]);
        @(negedge clk);
        for (int a = 4; a < 7; a++) rd(3'(a), snap[a]);
        @(negedge clk);
    endtask

    task automatic set_cal(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                           input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                           input logic [7:0] yr);
        wr(3'd6, yr); wr(3'd5, mo); wr(3'd4, dt); wr(3'd3, dw);
        wr(3'd2, h); wr(3'd1, mi); wr(3'd0, s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset values
        snap_all();
        chk("R11 reset fields", {snap[0], snap[1], snap[2], snap[3]}, 32'h00000001);
        chk("R11 reset date", {8'h00, snap[4], snap[5], snap[6]}, 32'h00010100);
        rd(3'd7, v);
        chk("R11 ctrl reads 0", {24'h0, v}, 32'h0);
        @(negedge clk);

        // R7, R1, R2: one minute of plain seconds
        wr(3'd2, 8'h12); wr(3'd1, 8'h00); wr(3'd0, 8'h00);
        repeat (CPS) @(negedge clk);
        rd(3'd0, v);
        chk("R7 no early advance", {24'h0, v}, 32'h00);
        @(negedge clk);
        for (int k = 1; k <= 61; k++) begin
            logic [7:0] s, m;
            rd(3'd0, s); rd(3'd1, m);
            chk("R1 seconds sweep", {16'h0, m, s}, {16'h0, bcd(k / 60), bcd(k % 60)});
            repeat (CPS) @(negedge clk);
        end

        // R2 minute and hour digit carry
        set_cal(8'h59, 8'h59, 8'h09, 8'h03, 8'h15, 8'h07, 8'h33);
        repeat (CPS + 1) @(negedge clk);
        snap_all();
        chk("R2 09:59:59 carry", {snap[2], snap[1], snap[0], snap[3]}, 32'h10000003);

        // R6 day of week
        for (int d = 1; d <= 7; d++) begin
            set_cal(8'h59, 8'h59, 8'h23, 8'(d), 8'h10, 8'h05, 8'h21);
            repeat (CPS + 1) @(negedge clk);
            snap_all();
            chk("R6 dow at midnight", {snap[3], snap[4], snap[2], 8'h0}, {8'((d % 7) + 1), 8'h11, 8'h00, 8'h0});
        end
        set_cal(8'h59, 8'h59, 8'h22, 8'h07, 8'h10, 8'h05, 8'h21);
        repeat (CPS + 1) @(negedge clk);
        snap_all();
        chk("R6 dow not at 23:00", {snap[3], snap[4], snap[2], 8'h0}, {8'h07, 8'h10, 8'h23, 8'h0});

        // R4 month-end rollover for every month and year
        for (int y = 0; y < 100; y++) begin
            for (int m = 1; m <= 12; m++) begin
                set_cal(8'h59, 8'h59, 8'h23, 8'h01, bcd(dim(m, y)), bcd(m), bcd(y));
                repeat (CPS + 1) @(negedge clk);
                snap_all();
                chk("R4 month end rollover", {snap[4], snap[5], snap[6], snap[2]},
                    {8'h01, bcd((m == 12) ? 1 : m + 1), bcd((m == 12) ? (y + 1) % 100 : y), 8'h00});
            end
            set_cal(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, bcd(y));
            repeat (CPS + 1) @(negedge clk);
            snap_all();
            chk("R4 february 28", {snap[4], snap[5], snap[6], 8'h0},
                {(y % 4 == 0) ? 8'h29 : 8'h01, (y % 4 == 0) ? 8'h02 : 8'h03, bcd(y), 8'h0});
        end

        // R5 century flag
        for (int c = 0; c < 4; c++) begin
            logic en, fl;
            en = c[1]; fl = c[0];
            set_cal(8'h59, 8'h59, {en, fl, 6'h23}, 8'h02, 8'h31, 8'h12, 8'h99);
            repeat (CPS + 1) @(negedge clk);
            snap_all();
            chk("R5 century at 99 wrap", {snap[2], snap[6], 16'h0}, {en, fl ^ en, 6'h00, 8'h00, 16'h0});
        end
        set_cal(8'h59, 8'h59, 8'hA3, 8'h02, 8'h31, 8'h12, 8'h98);
        repeat (CPS + 1) @(negedge clk);
        snap_all();
        chk("R5 no toggle at 98 wrap", {snap[2], snap[6], 16'h0}, {8'h80, 8'h99, 16'h0});

        // R3 stop bit
        wr(3'd0, 8'hB0);
        repeat (3 * CPS + 1) @(negedge clk);
        rd(3'd0, v);
        chk("R3 stopped seconds", {24'h0, v}, 32'hB0);
        @(negedge clk);
        wr(3'd0, 8'h30);
        repeat (CPS) @(negedge clk);
        rd(3'd0, v);
        chk("R3 resume not early", {24'h0, v}, 32'h30);
        @(negedge clk);
        rd(3'd0, v);
        chk("R3 resumed seconds", {24'h0, v}, 32'h31);
        @(negedge clk);

        // R11 register 7 ignored, R2 minutes bit 7 reads 0
        wr(3'd7, 8'hFF);
        @(negedge clk);
        rd(3'd7, v);
        chk("R11 ctrl write ignored", {24'h0, v}, 32'h0);
        @(negedge clk);
        wr(3'd1, 8'h85);
        @(negedge clk);
        rd(3'd1, v);
        chk("R2 minutes bit7 zero", {24'h0, v}, 32'h05);
        @(negedge clk);

        // R9 hold window expires during a long read
        wr(3'd0, 8'h20);
        rd_active = 1'b1;
        repeat (CPS + HOLD - 1) @(negedge clk);
        rd(3'd0, v);
        chk("R9 held before window", {24'h0, v}, 32'h20);
        @(negedge clk);
        rd(3'd0, v);
        chk("R9 released by window", {24'h0, v}, 32'h21);
        repeat (CPS) @(negedge clk);
        rd(3'd0, v);
        chk("R9 second release", {24'h0, v}, 32'h22);
        rd_active = 1'b0;
        @(negedge clk);

        // R9 read ends early
        wr(3'd0, 8'h40);
        rd_active = 1'b1;
        repeat (CPS + 1) @(negedge clk);
        rd(3'd0, v);
        chk("R9 held during read", {24'h0, v}, 32'h40);
        rd_active = 1'b0;
        @(negedge clk);
        rd(3'd0, v);
        chk("R9 released at read end", {24'h0, v}, 32'h41);
        @(negedge clk);

        // R8 tracking with one cycle lag, R10 live time during read
        wr(3'd0, 8'h10);
        rd(3'd0, v);
        chk("R8 lag before copy", {24'h0, v}, 32'h41);
        @(negedge clk);
        rd(3'd0, v);
        chk("R8 visible after copy", {24'h0, v}, 32'h10);
        wr(3'd0, 8'h10);
        rd_active = 1'b1;
        repeat (3 * CPS + 1) @(negedge clk);
        rd(3'd0, v);
        chk("R10 visible during read", {24'h0, v}, 32'h12);
        @(negedge clk);
        rd_active = 1'b0;
        @(negedge clk);
        rd(3'd0, v);
        chk("R10 live time after read", {24'h0, v}, 32'h13);
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule